// File: doc/BRIEF.md
# External Reset Pulse Generator

This block shapes the reset pulse that a watchdog drives off-chip once it expires. A single-cycle trigger from the watchdog starts one pulse. The pulse lasts a programmable number of microsecond ticks, and a 1 MHz tick-enable input paces it. The asserted level and the way the pad is driven are both programmable: the level can be high or low, and the pad can be driven at all times (push-pull) or only while the pulse is asserted (open-drain emulation through an output enable).

Software reaches one 32-bit configuration word through a plain write/read port. The low field holds the pulse length minus one, and every write to the word updates it. The two mode bits are guarded: they change only when the top byte of the write carries one of four key values. Any other top byte leaves both mode bits as they were. A read returns the polarity mode in bit 31, the drive mode in bit 30 and the length field in the low bits.

Top module: `ext_rst_pulse_gen`

## Requirements
- R1: After reset the length field is 0xFF, polarity is active-low and drive is open-drain. A read of the configuration word returns 0x000000FF, the pin sits at 1 and the output enable is 0.
- R2: Every write to the configuration address (0x18) stores wdata[19:0] in the length field, whatever the top byte, and a read returns it in bits 19:0.
- R3: A write whose top byte is 0xA5 selects active-high and one whose top byte is 0x5A selects active-low. Read bit 31 is 1 for active-high.
- R4: A write whose top byte is 0xA8 selects push-pull and one whose top byte is 0x8A selects open-drain. Read bit 30 is 1 for push-pull.
- R5: A write whose top byte is not one of the four keys leaves both mode bits unchanged, even when that byte has bits 31 or 30 set.
- R6: A pulse stays asserted for exactly (length + 1) tick-enable cycles, counted from the trigger. A length of 0 gives one tick.
- R7: While a pulse is asserted the pin equals 1 for active-high and 0 for active-low. When idle it holds the opposite level.
- R8: In push-pull mode the output enable is always 1. In open-drain mode it is 1 only while a pulse is asserted.
- R9: A trigger that arrives while a pulse is in progress is ignored and does not lengthen that pulse.
- R10: A length write made during a pulse does not change that pulse. It applies to the next pulse.
- R11: Writes to any address other than 0x18 change nothing, and reads from such an address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1us | input | 1 | One-cycle enable at 1 MHz that paces the pulse |
| trigger | input | 1 | Start request from the watchdog |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rst_pin | output | 1 | Pulse level with polarity applied |
| rst_oe | output | 1 | Pad output enable |

## Verification
A mode bit latched wrongly by the key decoder shows in the next read of bit 31 or 30 and, at once, in the idle level of rst_pin or in rst_oe. A counter that loads or decrements wrongly shows as a pulse one or more ticks too long or too short, so the bench counts ticks during every asserted phase. A busy flag that lets a second trigger restart the count, or a length that is read live instead of captured, shows as a longer pulse in the retrigger and mid-pulse write scenarios.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef struct packed {
    logic pol_high;
    logic push_pull;
  } mode_t;

  // Next mode after a write whose top byte is key.
  function automatic mode_t apply_key(mode_t cur, logic [7:0] key);
    mode_t nxt;
    nxt = cur;
    case (key)
      KEY_POL_HIGH: nxt.pol_high  = 1'b1;
      KEY_POL_LOW:  nxt.pol_high  = 1'b0;
      KEY_DRV_PP:   nxt.push_pull = 1'b1;
      KEY_DRV_OD:   nxt.push_pull = 1'b0;
      default:      nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic is_key(logic [7:0] key);
    return (key == KEY_POL_HIGH) || (key == KEY_POL_LOW) ||
           (key == KEY_DRV_PP)   || (key == KEY_DRV_OD);
  endfunction

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
  import rpg_pkg::*;
#(
  parameter int          DUR_W     = 20,
  parameter int          ADDR_W    = 8,
  parameter int unsigned CFG_ADDR  = 32'h18,
  parameter int unsigned RESET_DUR = 32'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              wr_hit,
  output logic [DUR_W-1:0]  dur,
  output mode_t             mode
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_ADDR);
  localparam logic [DUR_W-1:0]  DUR_INIT = DUR_W'(RESET_DUR);

  logic addr_hit;

  assign addr_hit = (addr == HIT_ADDR);
  assign wr_hit   = wr && addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur  <= DUR_INIT;
      mode <= '0;
    end else if (wr_hit) begin
      dur  <= wdata[DUR_W-1:0];
      mode <= apply_key(mode, wdata[31:24]);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr_hit) begin
      rdata[DUR_W-1:0] = dur;
      rdata[31]        = mode.pol_high;
      rdata[30]        = mode.push_pull;
    end
  end

endmodule

// File: rtl/rpg_timer.sv
module rpg_timer #(
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trigger,
  input  logic [DUR_W-1:0] dur,
  output logic             active,
  output logic             start_evt,
  output logic             end_evt
);

  logic [DUR_W-1:0] remain;

  assign start_evt = trigger && !active;
  assign end_evt   = active && tick && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start_evt) begin
      active <= 1'b1;
      remain <= dur;
    end else if (end_evt) begin
      active <= 1'b0;
    end else if (active && tick) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/rpg_drive.sv
module rpg_drive
  import rpg_pkg::*;
(
  input  logic  active,
  input  mode_t mode,
  output logic  pin,
  output logic  oe
);

  function automatic logic level_of(logic asserted, logic pol_high);
    return asserted ? pol_high : !pol_high;
  endfunction

  assign pin = level_of(active, mode.pol_high);
  assign oe  = mode.push_pull || active;

endmodule

// File: rtl/ext_rst_pulse_gen.sv
module ext_rst_pulse_gen
  import rpg_pkg::*;
#(
  parameter int          DUR_W     = 20,
  parameter int          ADDR_W    = 8,
  parameter int unsigned CFG_ADDR  = 32'h18,
  parameter int unsigned RESET_DUR = 32'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              trigger,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rst_pin,
  output logic              rst_oe
);

  logic             cfg_wr_hit;
  logic [DUR_W-1:0] cfg_dur;
  mode_t            cfg_mode;
  logic             mode_pol_high;
  logic             mode_push_pull;
  logic             pulse_active;
  logic             pulse_start;
  logic             pulse_end;

  rpg_cfg_reg #(
    .DUR_W(DUR_W), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .RESET_DUR(RESET_DUR)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .wr_hit(cfg_wr_hit),
    .dur   (cfg_dur),
    .mode  (cfg_mode)
  );

  assign mode_pol_high  = cfg_mode.pol_high;
  assign mode_push_pull = cfg_mode.push_pull;

  rpg_timer #(.DUR_W(DUR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1us),
    .trigger  (trigger),
    .dur      (cfg_dur),
    .active   (pulse_active),
    .start_evt(pulse_start),
    .end_evt  (pulse_end)
  );

  rpg_drive u_drive (
    .active(pulse_active),
    .mode  (cfg_mode),
    .pin   (rst_pin),
    .oe    (rst_oe)
  );

endmodule

// File: rtl/rpg_checker.sv
module rpg_checker
  import rpg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_hit,
  input logic [7:0] wr_key,
  input logic       pol_high,
  input logic       push_pull,
  input logic       active,
  input logic       tick,
  input logic       trigger,
  input logic       end_evt,
  input logic       pin,
  input logic       oe
);

  // R3
  pol_high_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_key == KEY_POL_HIGH) |=> pol_high);

  // R3
  pol_low_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_key == KEY_POL_LOW) |=> !pol_high);

  // R4
  drv_pp_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_key == KEY_DRV_PP) |=> push_pull);

  // R4
  drv_od_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_key == KEY_DRV_OD) |=> !push_pull);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit || !is_key(wr_key)) |=> ($stable(pol_high) && $stable(push_pull)));

  // R6
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(tick));

  // R7
  asserted_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (pin == pol_high));

  // R8
  pp_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |-> oe);

  // R8
  od_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull |-> (oe == active));

  // R9
  retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && trigger && !end_evt) |=> active);

endmodule

bind ext_rst_pulse_gen rpg_checker u_rpg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_hit   (cfg_wr_hit),
  .wr_key   (reg_wdata[31:24]),
  .pol_high (mode_pol_high),
  .push_pull(mode_push_pull),
  .active   (pulse_active),
  .tick     (tick_1us),
  .trigger  (trigger),
  .end_evt  (pulse_end),
  .pin      (rst_pin),
  .oe       (rst_oe)
);

// File: tb/tb_ext_rst_pulse_gen.sv
module tb_ext_rst_pulse_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        trigger = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h18;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_pin;
  logic        rst_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_div = 0;

  // bench model of the configuration
  bit      exp_pol = 1'b0;
  bit      exp_pp  = 1'b0;
  int      exp_dur = 32'hFF;

  ext_rst_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .trigger(trigger),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rst_pin(rst_pin), .rst_oe(rst_oe)
  );

  always #10 clk = ~clk;

  // tick enable: one cycle in four
  always @(negedge clk) begin
    tick_div <= (tick_div + 1) % 4;
    tick_1us <= (tick_div == 3);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h18;
    #1;
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = exp_dur & 32'hFFFFF;
    w[31] = exp_pol;
    w[30] = exp_pp;
    return w;
  endfunction

  // Runs one pulse; mid 0: plain, 1: retriggers, 2: width write mid-pulse.
  task automatic run_pulse(string req, int mid, int new_dur);
    int  nt = 0;
    bit  lvl_bad = 0;
    int  want = exp_dur + 1;
    check({req, " idle pin"}, {31'd0, rst_pin}, {31'd0, !exp_pol});
    check("R8 idle oe", {31'd0, rst_oe}, {31'd0, exp_pp});
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      #5;
      if (rst_pin !== exp_pol) break;
      if (rst_oe !== 1'b1) lvl_bad = 1;
      if (tick_1us) nt++;
      @(negedge clk);
      trigger = (mid == 1) && (i >= 2) && (i < 9);
      if (mid == 2 && i == 3) begin
        reg_wr = 1'b1; reg_wdata = new_dur; reg_addr = 8'h18;
      end else begin
        reg_wr = 1'b0;
      end
    end
    trigger = 1'b0; reg_wr = 1'b0;
    if (mid == 2) exp_dur = new_dur;
    check({req, " tick count"}, nt, want);
    check("R8 oe while asserted", {31'd0, lvl_bad}, 32'd0);
    #2;
    check("R7 pin after pulse", {31'd0, rst_pin}, {31'd0, !exp_pol});
    check("R8 oe after pulse", {31'd0, rst_oe}, {31'd0, exp_pp});
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset word", reg_rdata, 32'h000000FF);
    check("R1 reset pin", {31'd0, rst_pin}, 32'd1);
    check("R1 reset oe", {31'd0, rst_oe}, 32'd0);
  endtask

  task automatic t_keys();
    reg_write(8'h18, 32'hA5000010); exp_pol = 1; exp_dur = 32'h10;
    check("R3 active-high key", reg_rdata, exp_word());
    reg_write(8'h18, 32'hA8012345); exp_pp = 1; exp_dur = 32'h12345;
    check("R4 push-pull key", reg_rdata, exp_word());
    reg_write(8'h18, 32'h5A000020); exp_pol = 0; exp_dur = 32'h20;
    check("R3 active-low key", reg_rdata, exp_word());
    reg_write(8'h18, 32'hC00ABCDE); exp_dur = 32'hABCDE;
    check("R5 raw bits ignored", reg_rdata, exp_word());
    reg_write(8'h18, 32'h8A000007); exp_pp = 0; exp_dur = 7;
    check("R4 open-drain key", reg_rdata, exp_word());
    reg_write(8'h18, 32'hA4FFFFFF); exp_dur = 32'hFFFFF;
    check("R5 near-key ignored, R2 width taken", reg_rdata, exp_word());
    reg_write(8'h18, 32'h00000000); exp_dur = 0;
    check("R2 zero width", reg_rdata, exp_word());
  endtask

  task automatic t_addr();
    reg_write(8'h1C, 32'hA5A8FFFF);
    check("R11 other address write", reg_rdata, exp_word());
    reg_addr = 8'h1C; #1;
    check("R11 other address read", reg_rdata, 32'd0);
    reg_addr = 8'h18; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_pulse("R6 R1 default width", 0, 0);
    t_keys();
    t_addr();
    run_pulse("R6 zero width", 0, 0);
    reg_write(8'h18, 32'hA5000005); exp_pol = 1; exp_dur = 5;
    reg_write(8'h18, 32'hA8000005); exp_pp = 1;
    run_pulse("R7 active-high push-pull", 0, 0);
    reg_write(8'h18, 32'h5A000003); exp_pol = 0; exp_dur = 3;
    run_pulse("R8 active-low push-pull", 0, 0);
    reg_write(8'h18, 32'h8A000006); exp_pp = 0; exp_dur = 6;
    run_pulse("R9 retrigger", 1, 0);
    run_pulse("R9 trigger after end", 0, 0);
    reg_write(8'h18, 32'hA5000004); exp_pol = 1; exp_dur = 4;
    run_pulse("R10 mid-pulse write", 2, 20);
    check("R10 new width readback", reg_rdata, exp_word());
    run_pulse("R10 next pulse", 0, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule